// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Level Completion Interrupt

This block is a one-channel transfer engine that a processor programs through a small register window and then leaves alone. Software loads a memory start address, a device address, a byte count and a direction, then writes the control register with the start bit set. The engine then moves the bytes on its own. It moves each byte between a ready/acknowledge device port and a memory port that it drives as a bus master with a request/grant handshake. The processor takes no part in the per-byte work.

Progress is visible in the registers. The count register shows the bytes still to move and the address register shows the next memory location. The status register shows whether the engine is busy or finished. The interrupt is a level: it stays high for as long as the finished state holds and interrupts are enabled. Software clears it by acknowledging the finished state or by starting a new transfer. Clearing the enable bit hides the interrupt but does not stop or affect a transfer.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, the status reads 0 (busy bit 0 clear, done bit 1 clear), the count and address registers read 0, `irq` is low and `mem_req` is low.
- R2: The register window uses these offsets: 0 memory address, 1 device address, 2 byte count, 3 direction (bit 0), 4 control (bit 0 start, bit 1 interrupt enable), 5 status. A read strobe returns the selected value on `reg_rdata` one cycle later.
- R3: A control write with bit 0 set, a non-zero count and the engine idle sets busy and clears done at that clock edge.
- R4: With direction 0 (device to memory), each byte is taken from the device on a cycle with `dev_rdy` high. It is then written to memory at the current address, and consecutive bytes go to consecutive addresses.
- R5: With direction 1 (memory to device), each byte is read from memory at the current address. It is then handed to the device, in address order, on a cycle with `dev_rdy` high.
- R6: Each byte moved decrements the count register by one and increments the memory address register by one. After completion the count reads 0 and the address reads start plus length.
- R7: When the last byte is moved, done is set and busy is cleared in the same edge. Busy and done are never set together.
- R8: `irq` rises one cycle after done is set while the enable bit is 1, and stays high while done and enable both hold.
- R9: With the enable bit at 0, `irq` stays low and the transfer still completes. Setting the enable bit later while done holds raises `irq` one cycle after that write.
- R10: Writing the status register with bit 1 set clears done, and `irq` falls one cycle later.
- R11: Starting with a count of 0 sets done at the write edge and makes no memory request.
- R12: While busy, writes to the memory address, device address, count and direction registers have no effect.
- R13: A new start clears done, so an asserted `irq` falls one cycle after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| mem_req | output | 1 | Memory access request, held until granted |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in the grant cycle |
| mem_gnt | input | 1 | Grant; the access completes at the edge it is high |
| dev_addr | output | 8 | Programmed device address |
| dev_rdy | input | 1 | Device can supply or accept a byte |
| dev_rdata | input | 8 | Byte from the device |
| dev_ack | output | 1 | A byte is exchanged with the device this cycle |
| dev_wdata | output | 8 | Byte to the device |
| irq | output | 1 | Level completion interrupt |

## Verification
Register reads return one cycle after the strobe. Busy, done and the count change at the edge that samples the start write, the acknowledge or the final handshake. `irq` follows done and enable one cycle later. The bench drives every input at a falling edge and samples outputs at falling edges. It therefore checks `irq` exactly one and two falling edges after a start, an enable write or an acknowledge, to see both the lag and the new level. Transfers whose length depends on grant and ready timing are polled through the status register, and their results are checked afterward in memory, in the device sink and in the count and address registers.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [2:0] OFF_MADDR = 3'd0;
  localparam logic [2:0] OFF_DADDR = 3'd1;
  localparam logic [2:0] OFF_COUNT = 3'd2;
  localparam logic [2:0] OFF_DIR   = 3'd3;
  localparam logic [2:0] OFF_CTRL  = 3'd4;
  localparam logic [2:0] OFF_STAT  = 3'd5;

  localparam int CTRL_GO   = 0;
  localparam int CTRL_IE   = 1;
  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_DEV  = 2'd1,
    ENG_MEM  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int AW  = 16,
  parameter int DAW = 8,
  parameter int CW  = 16,
  parameter int RDW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  input  logic           step,
  input  logic           finish,
  output logic [AW-1:0]  maddr_o,
  output logic [DAW-1:0] daddr_o,
  output logic           dir_o,
  output logic           ie_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           start_o,
  output logic           zero_len_o,
  output logic           last_o
);
  import dma_pkg::*;

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0]  maddr_q;
  logic [DAW-1:0] daddr_q;
  logic [CW-1:0]  cnt_q;
  logic           dir_q, ie_q, busy_q, done_q;
  logic           cfg_we, start, ack;
  logic [RDW-1:0] rd_mux;
  logic           unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata;
  assign cfg_we = reg_wr && !busy_q;
  assign start  = reg_wr && (reg_addr == OFF_CTRL) && reg_wdata[CTRL_GO] && !busy_q;
  assign ack    = reg_wr && (reg_addr == OFF_STAT) && reg_wdata[STAT_DONE];

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFF_MADDR: rd_mux[AW-1:0]  = maddr_q;
      OFF_DADDR: rd_mux[DAW-1:0] = daddr_q;
      OFF_COUNT: rd_mux[CW-1:0]  = cnt_q;
      OFF_DIR:   rd_mux[0]       = dir_q;
      OFF_CTRL:  rd_mux[CTRL_IE] = ie_q;
      OFF_STAT: begin
        rd_mux[STAT_BUSY] = busy_q;
        rd_mux[STAT_DONE] = done_q;
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maddr_q   <= '0;
      daddr_q   <= '0;
      cnt_q     <= '0;
      dir_q     <= 1'b0;
      ie_q      <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (cfg_we && reg_addr == OFF_MADDR) maddr_q <= reg_wdata[AW-1:0];
      if (cfg_we && reg_addr == OFF_DADDR) daddr_q <= reg_wdata[DAW-1:0];
      if (cfg_we && reg_addr == OFF_COUNT) cnt_q   <= reg_wdata[CW-1:0];
      if (cfg_we && reg_addr == OFF_DIR)   dir_q   <= reg_wdata[0];
      if (step) begin
        maddr_q <= maddr_q + 1'b1;
        cnt_q   <= cnt_q - 1'b1;
      end
      if (reg_wr && reg_addr == OFF_CTRL) ie_q <= reg_wdata[CTRL_IE];
      if (start) begin
        busy_q <= (cnt_q != '0);
        done_q <= 1'b0;
      end
      if (ack) done_q <= 1'b0;
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assign maddr_o    = maddr_q;
  assign daddr_o    = daddr_q;
  assign dir_o      = dir_q;
  assign ie_o       = ie_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign start_o    = start;
  assign zero_len_o = (cnt_q == '0);
  assign last_o     = (cnt_q == CNT_ONE);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q));

  // R12
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          zero_len,
  input  logic          last,
  input  logic          dir_m2d,
  input  logic          dev_rdy,
  input  logic [BW-1:0] dev_rdata,
  output logic          dev_ack,
  output logic [BW-1:0] dev_wdata,
  output logic          mem_req,
  output logic          mem_we,
  input  logic          mem_gnt,
  input  logic [BW-1:0] mem_rdata,
  output logic [BW-1:0] mem_wdata,
  output logic          step,
  output logic          finish
);
  import dma_pkg::*;

  eng_state_t    state_q, state_d;
  logic [BW-1:0] buf_q;

  always_comb begin
    state_d = state_q;
    step    = 1'b0;
    finish  = 1'b0;
    dev_ack = 1'b0;
    mem_req = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start) begin
          if (zero_len)     finish  = 1'b1;
          else if (dir_m2d) state_d = ENG_MEM;
          else              state_d = ENG_DEV;
        end
      end
      ENG_DEV: begin
        dev_ack = dev_rdy;
        if (dev_rdy) begin
          if (dir_m2d) begin
            step    = 1'b1;
            finish  = last;
            state_d = last ? ENG_IDLE : ENG_MEM;
          end else begin
            state_d = ENG_MEM;
          end
        end
      end
      ENG_MEM: begin
        mem_req = 1'b1;
        if (mem_gnt) begin
          if (dir_m2d) begin
            state_d = ENG_DEV;
          end else begin
            step    = 1'b1;
            finish  = last;
            state_d = last ? ENG_IDLE : ENG_DEV;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ENG_DEV && dev_rdy && !dir_m2d) buf_q <= dev_rdata;
      if (state_q == ENG_MEM && mem_gnt && dir_m2d)  buf_q <= mem_rdata;
    end
  end

  assign mem_we    = !dir_m2d;
  assign mem_wdata = buf_q;
  assign dev_wdata = buf_q;

  // R11
  zero_no_move_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ENG_IDLE && start && zero_len) |=> (state_q == ENG_IDLE));

  // R4
  d2m_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ENG_DEV && dev_rdy && !dir_m2d) |=> (state_q == ENG_MEM));
endmodule

// File: rtl/dma_irq.sv
module dma_irq (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic ie,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= done && ie;
  end

  assign irq_o = irq_q;

  // R10
  irq_ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |=> !irq_q);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int AW  = 16,
  parameter int DAW = 8,
  parameter int CW  = 16,
  parameter int BW  = 8,
  parameter int RDW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [BW-1:0]  mem_wdata,
  input  logic [BW-1:0]  mem_rdata,
  input  logic           mem_gnt,
  output logic [DAW-1:0] dev_addr,
  input  logic           dev_rdy,
  input  logic [BW-1:0]  dev_rdata,
  output logic           dev_ack,
  output logic [BW-1:0]  dev_wdata,
  output logic           irq
);
  logic step, finish, dir, ie, busy, done, start, zero_len, last;

  dma_regs #(.AW(AW), .DAW(DAW), .CW(CW), .RDW(RDW)) regs_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .step(step), .finish(finish),
    .maddr_o(mem_addr), .daddr_o(dev_addr), .dir_o(dir), .ie_o(ie),
    .busy_o(busy), .done_o(done), .start_o(start),
    .zero_len_o(zero_len), .last_o(last)
  );

  dma_engine #(.BW(BW)) eng_i (
    .clk(clk), .rst(rst),
    .start(start), .zero_len(zero_len), .last(last), .dir_m2d(dir),
    .dev_rdy(dev_rdy), .dev_rdata(dev_rdata), .dev_ack(dev_ack),
    .dev_wdata(dev_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .step(step), .finish(finish)
  );

  dma_irq irq_i (
    .clk(clk), .rst(rst), .done(done), .ie(ie), .irq_o(irq)
  );

  // R4
  mem_req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R6
  step_busy_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> busy);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (done && ie) |=> irq);
endmodule

// File: tb/dma_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt, dev_rdy, dev_ack, irq;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, dev_rdata, dev_wdata, dev_addr;

  int checks = 0, errors = 0, cycles = 0, req_cycles = 0;
  int gnt_lat = 1, wcnt = 0, ph = 0;
  logic dev_en = 1'b0;
  logic [7:0] mem [0:255];
  logic [7:0] snk [0:15];
  int snk_idx = 0, src_idx = 0;
  logic [7:0] src_base = 8'h00;

  always #2.5 clk = ~clk;

  dma_chan_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
    .dev_addr(dev_addr), .dev_rdy(dev_rdy), .dev_rdata(dev_rdata),
    .dev_ack(dev_ack), .dev_wdata(dev_wdata), .irq(irq)
  );

  assign mem_gnt   = mem_req && (wcnt >= gnt_lat);
  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_rdy   = dev_en && (ph == 0);
  assign dev_rdata = src_base + 8'(src_idx);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    ph <= (ph == 2) ? 0 : ph + 1;
    if (mem_req) req_cycles <= req_cycles + 1;
    if (mem_req && !mem_gnt) wcnt <= wcnt + 1; else wcnt <= 0;
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (dev_ack) begin
      src_idx <= src_idx + 1;
      snk[snk_idx[3:0]] <= dev_wdata;
      snk_idx <= snk_idx + 1;
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd5, s);
      if (s[1]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 mem_req", {31'b0, mem_req}, 0);
    rd(3'd5, d); check("R1 status", d, 0);
    rd(3'd2, d); check("R1 count", d, 0);
    rd(3'd0, d); check("R1 maddr", d, 0);
  endtask

  task automatic t_program();
    logic [31:0] d;
    wr(3'd0, 32'h0020); wr(3'd1, 32'h5A); wr(3'd2, 32'd3); wr(3'd3, 32'd1);
    rd(3'd0, d); check("R2 maddr", d, 32'h20);
    rd(3'd1, d); check("R2 daddr", d, 32'h5A);
    check("R2 dev_addr port", {24'b0, dev_addr}, 32'h5A);
    rd(3'd2, d); check("R2 count", d, 3);
    rd(3'd3, d); check("R2 dir", d, 1);
  endtask

  task automatic t_dev_to_mem();
    logic [31:0] d;
    gnt_lat = 2; src_base = 8'hA0; src_idx = 0; dev_en = 1'b1;
    wr(3'd0, 32'h40); wr(3'd2, 32'd5); wr(3'd3, 32'd0);
    wr(3'd4, 32'h3);
    rd(3'd5, d); check("R3 busy after start", d, 32'h1);
    wait_done();
    for (int i = 0; i < 5; i++) check("R4 mem byte", {24'b0, mem[8'h40 + 8'(i)]}, 32'hA0 + i);
    rd(3'd2, d); check("R6 count end", d, 0);
    rd(3'd0, d); check("R6 maddr end", d, 32'h45);
    rd(3'd5, d); check("R7 status done", d, 32'h2);
    check("R8 irq high", {31'b0, irq}, 1);
  endtask

  task automatic t_ack();
    wr(3'd5, 32'h2);
    check("R10 irq lags ack", {31'b0, irq}, 1);
    @(negedge clk);
    check("R10 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_mem_to_dev();
    logic [31:0] d;
    gnt_lat = 0; snk_idx = 0;
    for (int i = 0; i < 4; i++) mem[8'h80 + 8'(i)] = 8'h30 + 8'(i * 7);
    wr(3'd0, 32'h80); wr(3'd2, 32'd4); wr(3'd3, 32'd1);
    wr(3'd4, 32'h1);
    wait_done();
    for (int i = 0; i < 4; i++) check("R5 sink byte", {24'b0, snk[i]}, 32'h30 + i * 7);
    check("R5 sink count", snk_idx, 4);
    check("R9 irq masked", {31'b0, irq}, 0);
    wr(3'd4, 32'h2);
    check("R9 irq lag", {31'b0, irq}, 0);
    @(negedge clk);
    check("R9 irq after enable", {31'b0, irq}, 1);
    wr(3'd5, 32'h2);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    int r0;
    r0 = req_cycles;
    wr(3'd2, 32'd0);
    wr(3'd4, 32'h3);
    check("R8 irq one cycle late", {31'b0, irq}, 0);
    @(negedge clk);
    check("R11 irq after zero len", {31'b0, irq}, 1);
    rd(3'd5, d); check("R11 status", d, 32'h2);
    check("R11 no mem req", req_cycles - r0, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    dev_en = 1'b0; src_base = 8'h60; src_idx = 0; gnt_lat = 1;
    wr(3'd0, 32'h10); wr(3'd2, 32'd3); wr(3'd3, 32'd0);
    wr(3'd4, 32'h3);
    check("R13 irq lag on restart", {31'b0, irq}, 1);
    @(negedge clk);
    check("R13 irq drop", {31'b0, irq}, 0);
    rd(3'd5, d); check("R3 busy", d, 32'h1);
    wr(3'd2, 32'd9); wr(3'd0, 32'h99); wr(3'd3, 32'd1); wr(3'd1, 32'h77);
    rd(3'd2, d); check("R12 count kept", d, 3);
    rd(3'd0, d); check("R12 maddr kept", d, 32'h10);
    rd(3'd3, d); check("R12 dir kept", d, 0);
    rd(3'd1, d); check("R12 daddr kept", d, 32'h5A);
    dev_en = 1'b1;
    wait_done();
    for (int i = 0; i < 3; i++) check("R4 mem byte 2", {24'b0, mem[8'h10 + 8'(i)]}, 32'h60 + i);
    rd(3'd0, d); check("R6 maddr end 2", d, 32'h13);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_dev_to_mem();
    t_ack();
    t_mem_to_dev();
    t_zero();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule